// File: doc/BRIEF.md
# Parallel 16-Point Radix-4 FFT

This block computes the forward discrete Fourier transform of sixteen complex samples at once. A caller places all sixteen samples on two flat input buses, one for real parts and one for imaginary parts, and raises `start` for one cycle. The block registers the frame and splits it into four interleaved groups. It runs a 4-point butterfly on each group, applies fixed twiddle factors, and then runs a second rank of 4-point butterflies across the groups. A fixed number of cycles later it presents all sixteen frequency bins together on two flat output buses and raises `done`.

Both the samples and the bins are in natural index order. The index reordering that radix-4 decimation in time needs is done entirely by wiring between the ranks. The pipeline accepts a new frame on every cycle. Each frame leaves after the same latency and in the order it entered.

Arithmetic is two's complement fixed point. Samples are whole numbers, and every internal word and output carries 8 fractional bits. The butterflies are exact. Each non-trivial twiddle product is truncated back to 8 fractional bits.

Top module: `fft16_par`

## Requirements
- R1: Bin k appears at bits [20k+19:20k] of `out_re` and `out_im`. Sample n is taken from bits [8n+7:8n] of `in_re` and `in_im`. Each output equals 256·X[k], with X[k] = Σ x[n]·e^(−j2πnk/16), to within 12 LSB. This holds whenever every exact bin part stays below 2047 in magnitude.
- R2: Each input part is an 8-bit two's complement integer, and the full range −128..127 is handled.
- R3: Each output part is a 20-bit two's complement word: 12 integer bits above 8 fractional bits. A frame that is zero except at sample 0, or a frame of sixteen equal samples, gives the exact result with no error.
- R4: `done` is high in the cycle after the fifth rising edge, counting the edge that samples `start` high. `done` is never high without such a start.
- R5: `start` may be high on consecutive cycles. Every frame is transformed, and the results appear on consecutive cycles in the order the frames were given.
- R6: Reset is synchronous and active high. After an edge with `rst` high, `done` is low and both output buses are zero. Frames in flight at that edge never produce `done`.
- R7: While `done` is low, the output buses keep the last result. Changes on `in_re` and `in_im` while `start` is low have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load the input frame this cycle |
| in_re | input | 128 | Real parts of 16 samples, 8 bits each |
| in_im | input | 128 | Imaginary parts of 16 samples, 8 bits each |
| out_re | output | 320 | Real parts of 16 bins, 20 bits each |
| out_im | output | 320 | Imaginary parts of 16 bins, 20 bits each |
| done | output | 1 | Outputs hold a new result this cycle |

## Verification
A wrong wire in the inter-rank permutation or a wrong twiddle sign shows up in the very frame that passes through it, five cycles after its start. It appears as energy in the wrong bin or as a mirrored phase. Impulses away from sample 0 and off-grid tones expose this even where a DC or origin impulse would not. A broken valid chain or a bad load enable shows at once as a `done` pulse in the wrong cycle, as back-to-back frames swapping or repeating, or as output words changing while `done` is low. A reset that fails to clear the in-flight flags shows up as a stray `done` within five cycles after reset is released.

// File: rtl/fft16_pkg.sv
`timescale 1ns/1ps
package fft16_pkg;
    localparam int PTS      = 16;
    localparam int RDX      = 4;
    localparam int IN_W     = 8;
    localparam int DW       = 20;
    localparam int FRAC     = 8;
    localparam int TW_FRAC  = 16;
    localparam int TW_W     = TW_FRAC + 2;
    localparam int PROD_W   = DW + TW_W + 1;
    localparam int PIPE_LAT = 5;
    localparam int PAD_W    = DW - IN_W - FRAC;

    typedef logic signed [DW-1:0]   word_t;
    typedef logic signed [TW_W-1:0] coef_t;

    typedef struct packed {
        word_t re;
        word_t im;
    } cplx_t;

    typedef cplx_t [RDX-1:0] quad_t;
    typedef cplx_t [PTS-1:0] frame_t;

    // cos(oct * pi/8) scaled by 2^16, for oct in 0..4
    function automatic int base_cos(input int oct);
        case (oct)
            0:       return 65536;
            1:       return 60547;
            2:       return 46341;
            3:       return 25080;
            default: return 0;
        endcase
    endfunction

    // cos(2*pi*m/16) in TW_FRAC fractional bits, folded by quadrant symmetry
    function automatic coef_t cos16(input int m);
        int r;
        int c;
        int sh;
        r = ((m % PTS) + PTS) % PTS;
        if (r <= 4)       c = base_cos(r);
        else if (r <= 8)  c = -base_cos(8 - r);
        else if (r <= 12) c = -base_cos(r - 8);
        else              c = base_cos(16 - r);
        sh = 16 - TW_FRAC;
        if (sh > 0)      c = (c + (1 <<< (sh - 1))) >>> sh;
        else if (sh < 0) c = c <<< (-sh);
        return coef_t'(c);
    endfunction

    // sin(theta) = cos(theta - pi/2)
    function automatic coef_t sin16(input int m);
        return cos16(m + 12);
    endfunction

    // Integer sample to internal word with FRAC fractional bits
    function automatic word_t widen(input logic [IN_W-1:0] s);
        return {{PAD_W{s[IN_W-1]}}, s, {FRAC{1'b0}}};
    endfunction
endpackage

// File: rtl/fft16_bfly4.sv
`timescale 1ns/1ps
module fft16_bfly4
    import fft16_pkg::*;
(
    input  quad_t x,
    output quad_t y
);
    word_t ar, ai, br, bi, cr, ci, dr, di;

    // 4-point DFT; the factors +-j become part swaps, so no multiplier is needed
    always_comb begin
        ar = x[0].re; ai = x[0].im;
        br = x[1].re; bi = x[1].im;
        cr = x[2].re; ci = x[2].im;
        dr = x[3].re; di = x[3].im;
        y[0].re = ar + br + cr + dr;
        y[0].im = ai + bi + ci + di;
        y[1].re = ar + bi - cr - di;
        y[1].im = ai - br - ci + dr;
        y[2].re = ar - br + cr - dr;
        y[2].im = ai - bi + ci - di;
        y[3].re = ar - bi - cr + di;
        y[3].im = ai + br - ci - dr;
    end
endmodule

// File: rtl/fft16_twmul.sv
`timescale 1ns/1ps
module fft16_twmul
    import fft16_pkg::*;
#(
    parameter int M = 0
) (
    input  cplx_t a,
    output cplx_t b
);
    generate
        if ((M % PTS) == 0) begin : g_pass
            // unit twiddle: exact, no truncation
            assign b = a;
        end else begin : g_mul
            localparam coef_t WR = cos16(M);
            localparam coef_t WI = coef_t'(-sin16(M));
            logic signed [PROD_W-1:0] xr_e, xi_e, wr_e, wi_e, pre, pim;
            always_comb begin
                xr_e = a.re;
                xi_e = a.im;
                wr_e = WR;
                wi_e = WI;
                pre  = xr_e * wr_e - xi_e * wi_e;
                pim  = xr_e * wi_e + xi_e * wr_e;
                // arithmetic shift = truncation toward minus infinity
                b.re = word_t'(pre >>> TW_FRAC);
                b.im = word_t'(pim >>> TW_FRAC);
            end
        end
    endgenerate
endmodule

// File: rtl/fft16_par.sv
`timescale 1ns/1ps
module fft16_par
    import fft16_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [PTS*IN_W-1:0]  in_re,
    input  logic [PTS*IN_W-1:0]  in_im,
    output logic [PTS*DW-1:0]    out_re,
    output logic [PTS*DW-1:0]    out_im,
    output logic                 done
);
    frame_t in_d, s1_d, tw_d, s2_d;
    frame_t r_in, r_s1, r_tw, r_s2, r_out;
    logic   v_in, v_s1, v_tw, v_s2, v_out;

    // input widening
    always_comb begin
        for (int n = 0; n < PTS; n++) begin
            in_d[n].re = widen(in_re[n*IN_W +: IN_W]);
            in_d[n].im = widen(in_im[n*IN_W +: IN_W]);
        end
    end

    // rank 1: butterfly n2 takes samples n = RDX*n1 + n2, result at index RDX*n2 + k1
    // twiddle W16^(n2*k1) applied to each rank 1 result
    // rank 2: butterfly k1 takes index RDX*n2 + k1, bin k1 + RDX*k2 (natural order)
    generate
        for (genvar g = 0; g < RDX; g++) begin : g_rank
            quad_t b1_x, b1_y, b2_x, b2_y;
            for (genvar h = 0; h < RDX; h++) begin : g_wire
                assign b1_x[h]           = r_in[RDX*h + g];
                assign s1_d[RDX*g + h]   = b1_y[h];
                assign b2_x[h]           = r_tw[RDX*h + g];
                assign s2_d[g + RDX*h]   = b2_y[h];
                fft16_twmul #(.M(g*h)) u_tw (
                    .a (r_s1[RDX*g + h]),
                    .b (tw_d[RDX*g + h])
                );
            end
            fft16_bfly4 u_b1 (.x(b1_x), .y(b1_y));
            fft16_bfly4 u_b2 (.x(b2_x), .y(b2_y));
        end
    endgenerate

    // valid chain
    always_ff @(posedge clk) begin
        if (rst) begin
            v_in  <= 1'b0;
            v_s1  <= 1'b0;
            v_tw  <= 1'b0;
            v_s2  <= 1'b0;
            v_out <= 1'b0;
        end else begin
            v_in  <= start;
            v_s1  <= v_in;
            v_tw  <= v_s1;
            v_s2  <= v_tw;
            v_out <= v_s2;
        end
    end

    // datapath stage registers, loaded only behind a valid flag
    always_ff @(posedge clk) begin
        if (start) r_in <= in_d;
        if (v_in)  r_s1 <= s1_d;
        if (v_s1)  r_tw <= tw_d;
        if (v_tw)  r_s2 <= s2_d;
    end

    always_ff @(posedge clk) begin
        if (rst)       r_out <= '0;
        else if (v_s2) r_out <= r_s2;
    end

    always_comb begin
        for (int k = 0; k < PTS; k++) begin
            out_re[k*DW +: DW] = r_out[k].re;
            out_im[k*DW +: DW] = r_out[k].im;
        end
    end
    assign done = v_out;

    // R4: a start leads to done after the fixed latency
    p_start_done_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> ##PIPE_LAT done);

    // R4: done only ever follows a start
    p_done_source_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, PIPE_LAT));

    // R6: an edge with reset leaves the outputs cleared
    p_reset_clear_r6: assert property (@(posedge clk)
        $past(rst) |-> (!done && out_re == '0 && out_im == '0));

    // R7: results are held while no new frame is presented
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> ($stable(out_re) && $stable(out_im)));
endmodule

// File: tb/fft16_par_test.sv
`timescale 1ns/1ps
module fft16_par_test;
    localparam int NP  = 16;
    localparam int IW  = 8;
    localparam int OW  = 20;
    localparam int LAT = 5;
    localparam int TOL = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [NP*IW-1:0]  in_re = '0;
    logic [NP*IW-1:0]  in_im = '0;
    logic [NP*OW-1:0]  out_re, out_im;
    logic              done;

    fft16_par uut (
        .clk(clk), .rst(rst), .start(start),
        .in_re(in_re), .in_im(in_im),
        .out_re(out_re), .out_im(out_im), .done(done)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int              due;
        logic [NP*IW-1:0] xr;
        logic [NP*IW-1:0] xi;
        bit              exact;
        string           tag;
    } item_t;

    item_t            q[$];
    int               cyc = 0;
    logic             rst_q = 1'b1;
    int               nchk = 0;
    int               nerr = 0;
    bit               ended = 0;
    logic [NP*OW-1:0] last_re = '0;
    logic [NP*OW-1:0] last_im = '0;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        rst_q <= rst;
    end

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    // exact DFT bin scaled by 256
    task automatic ref_bin(input logic [NP*IW-1:0] xr, input logic [NP*IW-1:0] xi,
                           input int k, output real er, output real ei);
        er = 0.0;
        ei = 0.0;
        for (int n = 0; n < NP; n++) begin
            int  a;
            int  b;
            real ang;
            a   = $signed(xr[n*IW +: IW]);
            b   = $signed(xi[n*IW +: IW]);
            ang = 2.0 * 3.14159265358979 * real'(n * k) / real'(NP);
            er  = er + a * $cos(ang) + b * $sin(ang);
            ei  = ei + b * $cos(ang) - a * $sin(ang);
        end
        er = er * 256.0;
        ei = ei * 256.0;
    endtask

    task automatic compare(input item_t it);
        bit ok;
        ok = 1;
        nchk++;
        for (int k = 0; k < NP; k++) begin
            real er, ei, lim;
            int  ar, ai;
            ref_bin(it.xr, it.xi, k, er, ei);
            ar  = $signed(out_re[k*OW +: OW]);
            ai  = $signed(out_im[k*OW +: OW]);
            lim = it.exact ? 0.5 : real'(TOL);
            if (ok && ((real'(ar) - er > lim) || (er - real'(ar) > lim) ||
                       (real'(ai) - ei > lim) || (ei - real'(ai) > lim))) begin
                ok = 0;
                nerr++;
                $display("FAIL %s bin %0d: actual (%0d,%0d) expected (%0.2f,%0.2f)",
                         it.tag, k, ar, ai, er, ei);
            end
        end
    endtask

    // cycle-by-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_q) begin
            nchk++;
            if (done !== 1'b0 || out_re !== '0 || out_im !== '0) begin
                nerr++;
                $display("FAIL R6 reset state: actual done=%0b outs_zero=%0b expected done=0 outs_zero=1",
                         done, (out_re == '0 && out_im == '0));
            end
            last_re = '0;
            last_im = '0;
        end else begin
            bit want;
            want = (q.size() > 0 && q[0].due == cyc);
            nchk++;
            if (done !== want) begin
                nerr++;
                $display("FAIL R4 done at cycle %0d: actual %0b expected %0b", cyc, done, want);
            end
            if (want) begin
                item_t it;
                it = q.pop_front();
                compare(it);
            end else if (!done) begin
                nchk++;
                if (out_re !== last_re || out_im !== last_im) begin
                    nerr++;
                    $display("FAIL R7 outputs changed while idle: actual differs, expected held result");
                end
            end
            if (done) begin
                last_re = out_re;
                last_im = out_im;
            end
        end
    end

    task automatic issue(input logic [NP*IW-1:0] xr, input logic [NP*IW-1:0] xi,
                         input bit exact, input string tag);
        item_t it;
        start    = 1'b1;
        in_re    = xr;
        in_im    = xi;
        it.due   = cyc + LAT;
        it.xr    = xr;
        it.xi    = xi;
        it.exact = exact;
        it.tag   = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic rand_vec(output logic [NP*IW-1:0] xr, output logic [NP*IW-1:0] xi);
        for (int n = 0; n < NP; n++) begin
            xr[n*IW +: IW] = IW'(int'($urandom_range(180)) - 90);
            xi[n*IW +: IW] = IW'(int'($urandom_range(180)) - 90);
        end
    endtask

    // idle cycles with scrambled data inputs (start low: R7)
    task automatic idle(input int cycles);
        start = 1'b0;
        for (int c = 0; c < cycles; c++) begin
            logic [NP*IW-1:0] xr, xi;
            rand_vec(xr, xi);
            in_re = xr;
            in_im = xi;
            @(negedge clk);
        end
    endtask

    task automatic tone(input int bin, input int amp,
                        output logic [NP*IW-1:0] xr, output logic [NP*IW-1:0] xi);
        for (int n = 0; n < NP; n++) begin
            real ang;
            ang = 2.0 * 3.14159265358979 * real'(bin * n) / real'(NP);
            xr[n*IW +: IW] = IW'($rtoi(amp * $cos(ang)));
            xi[n*IW +: IW] = IW'($rtoi(amp * $sin(ang)));
        end
    endtask

    initial begin
        logic [NP*IW-1:0] xr, xi;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R3: impulse at sample 0, exact
        xr = '0; xi = '0; xr[7:0] = 8'd100;
        issue(xr, xi, 1, "R3 impulse");
        idle(6);
        // R2: extreme signed parts at sample 0, exact
        xr = '0; xi = '0; xr[7:0] = 8'h80; xi[7:0] = 8'h7F;
        issue(xr, xi, 1, "R2 impulse extremes");
        idle(6);
        // R3 and R2: constant -128 frame, bin 0 real = -524288
        xr = {NP{8'h80}}; xi = '0;
        issue(xr, xi, 1, "R3 dc min");
        idle(6);
        xr = {NP{8'd5}}; xi = {NP{8'hF9}};
        issue(xr, xi, 1, "R3 dc mixed");
        idle(6);
        // R1: impulse off origin exercises the permutation and twiddles
        xr = '0; xi = '0; xr[3*IW +: IW] = 8'd64; xi[3*IW +: IW] = 8'hD0;
        issue(xr, xi, 0, "R1 impulse n3");
        idle(6);
        tone(3, 80, xr, xi);
        issue(xr, xi, 0, "R1 tone bin3");
        idle(6);
        tone(11, 70, xr, xi);
        issue(xr, xi, 0, "R1 tone bin11");
        idle(6);
        rand_vec(xr, xi);
        issue(xr, xi, 0, "R1 random");
        idle(7);

        // R5: back-to-back frames
        for (int i = 0; i < 6; i++) begin
            rand_vec(xr, xi);
            issue(xr, xi, 0, "R5 back-to-back");
        end
        idle(10);

        // R6: reset with a frame in flight
        rand_vec(xr, xi);
        issue(xr, xi, 0, "R6 in flight");
        idle(1);
        rst = 1'b1;
        q.delete();
        idle(2);
        rst = 1'b0;
        for (int c = 0; c < 8; c++) begin
            nchk++;
            if (done !== 1'b0) begin
                nerr++;
                $display("FAIL R6 discarded frame: actual done=%0b expected 0", done);
            end
            @(negedge clk);
        end

        for (int i = 0; i < 4; i++) begin
            rand_vec(xr, xi);
            issue(xr, xi, 0, "R5 after reset");
        end
        idle(12);
        summary();
    end

    initial begin
        #(200000 * 5.0);
        nerr++;
        $display("FAIL R4 watchdog: actual run hung, expected completion");
        summary();
    end
endmodule